// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

This block is a software watchdog. It counts cycles of its reference clock, and software must restart the count before it reaches a selected limit. If the count reaches the limit first, the block pulses a reset-request output for one clock and starts counting again. To restart the count, software writes two key bytes to a service register, always in the same order. Any number of idle cycles and control-register writes may fall between the two keys.

A control register sets up the watchdog. It holds an enable, a prescale bit and a two-bit period select. The enable and the prescale bit can be written only once after reset. The period select stays writable, but a new select is held as pending and only replaces the active one when the next service completes. The prescale bit's reset value comes from a mode strap: it is set to the inverse of the strap, captured on the first clock after reset is released.

Top module: `svc_watchdog`

## Requirements
- R1: A service write (wr_sel_i = 0) of 8'h55, followed later by a service write of 8'hAA, completes a service. The count restarts from zero at that write's clock edge, and the next reset request appears exactly L clock edges after that edge, where L is the active period.
- R2: Idle cycles and control-register writes (wr_sel_i = 1) placed between the 8'h55 and 8'hAA service writes do not stop the pair from completing a service.
- R3: A service write of 8'hAA with no armed 8'h55 before it has no effect. A service write of any value other than 8'h55 or 8'hAA cancels a pending 8'h55. In both cases the period in progress is not shortened or restarted.
- R4: Control byte fields are: bit 7 enable, bit 2 prescale, bits 1:0 period select S. The active period is L = 2^(BASE_LOG2 + STEP_LOG2*S) clocks, multiplied by 2^PRESC_LOG2 when prescale is 1. With the default parameters this gives 2^9, 2^11, 2^13 or 2^15 clocks, times 2^9 when prescaled.
- R5: A newly written period select does not change the running period. It becomes active only when the next service completes.
- R6: After reset the watchdog is enabled with period select 0, and the prescale bit equals the inverse of strap_i sampled on the first clock edge after rst_n rises.
- R7: Only the first control write after reset sets the enable and prescale bits. Later control writes leave both unchanged and only update the pending period select.
- R8: When the period runs out while the watchdog is enabled, rst_req_o is high for exactly one clock. Counting then restarts, so an unserviced watchdog requests reset once every L clocks.
- R9: While the watchdog is disabled, rst_req_o stays low, and service writes and later enable writes do not bring it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 1 | Mode strap; its inverse becomes the prescale bit after reset |
| wr_en_i | input | 1 | Register write strobe, one write per clock it is high |
| wr_sel_i | input | 1 | Register select: 0 = service register, 1 = control register |
| wr_data_i | input | 8 | Write data |
| rst_req_o | output | 1 | One-clock reset request on watchdog expiry |

## Verification
The assertions assume that each write carries exactly one register select and one byte, and that strap_i is steady around reset release. The bench drives writes only on falling clock edges, holds each write for one cycle, and changes the strap only while reset is held. The assertions also assume that every active period is at least two clocks long, so that the single-pulse check stays meaningful. The bench instantiates the block with a shortest period of eight clocks. The expected periods in the sweeps over strap, prescale and select are computed from the formula in R4.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int          TSEL_W   = 2;
    localparam logic [7:0]  KEY_ARM  = 8'h55;
    localparam logic [7:0]  KEY_FIRE = 8'hAA;

    // control byte field positions
    localparam int CTRL_EN_POS = 7;
    localparam int CTRL_PS_POS = 2;

    typedef struct packed {
        logic armed;
    } seq_state_t;

    typedef struct packed {
        logic              en;
        logic              presc;
        logic              locked;
        logic              boot;
        logic [TSEL_W-1:0] tsel_pend;
        logic [TSEL_W-1:0] tsel_act;
    } cfg_state_t;

endpackage

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       svc_wr_i,
    input  logic [7:0] data_i,
    output logic       done_o
);

    seq_state_t st_q, st_d;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (svc_wr_i) begin
            if (data_i == KEY_ARM) begin
                st_d.armed = 1'b1;
            end else if (data_i == KEY_FIRE) begin
                if (st_q.armed) begin
                    done_o     = 1'b1;
                    st_d.armed = 1'b0;
                end
            end else begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              wr_i,
    input  logic              en_wr_i,
    input  logic              ps_wr_i,
    input  logic [TSEL_W-1:0] tsel_wr_i,
    input  logic              svc_done_i,
    output logic              en_o,
    output logic              presc_o,
    output logic [TSEL_W-1:0] tsel_o
);

    localparam cfg_state_t CFG_RST = '{
        en:        1'b1,
        presc:     1'b0,
        locked:    1'b0,
        boot:      1'b1,
        tsel_pend: '0,
        tsel_act:  '0
    };

    cfg_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.boot = 1'b0;
        if (st_q.boot) st_d.presc = ~strap_i;
        if (wr_i) begin
            st_d.tsel_pend = tsel_wr_i;
            if (!st_q.locked) begin
                st_d.en     = en_wr_i;
                st_d.presc  = ps_wr_i;
                st_d.locked = 1'b1;
            end
        end
        if (svc_done_i) st_d.tsel_act = st_q.tsel_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_RST;
        else        st_q <= st_d;
    end

    assign en_o    = st_q.en;
    assign presc_o = st_q.presc;
    assign tsel_o  = st_q.tsel_act;

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2  = 9,
    parameter int STEP_LOG2  = 2,
    parameter int PRESC_LOG2 = 9,
    parameter int CNT_W      = BASE_LOG2 + STEP_LOG2 * ((1 << TSEL_W) - 1) + PRESC_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              presc_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic              reload_i,
    output logic              req_o
);

    localparam logic [CNT_W-1:0] ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_state_t;

    cnt_state_t       st_q, st_d;
    int               sh;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        sh       = BASE_LOG2 + STEP_LOG2 * int'(tsel_i) + (presc_i ? PRESC_LOG2 : 0);
        last_cnt = ONES >> (CNT_W - sh);
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (reload_i || !en_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= last_cnt) begin
            st_d.cnt = '0;
            st_d.req = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2  = 9,
    parameter int STEP_LOG2  = 2,
    parameter int PRESC_LOG2 = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_i,
    input  logic       wr_en_i,
    input  logic       wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic       rst_req_o
);

    localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * ((1 << TSEL_W) - 1) + PRESC_LOG2;

    logic              svc_wr;
    logic              ctrl_wr;
    logic              svc_done;
    logic              cfg_en;
    logic              cfg_presc;
    logic [TSEL_W-1:0] cfg_tsel;

    assign svc_wr  = wr_en_i & ~wr_sel_i;
    assign ctrl_wr = wr_en_i &  wr_sel_i;

    wdog_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr_i (svc_wr),
        .data_i   (wr_data_i),
        .done_o   (svc_done)
    );

    wdog_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_i),
        .wr_i       (ctrl_wr),
        .en_wr_i    (wr_data_i[CTRL_EN_POS]),
        .ps_wr_i    (wr_data_i[CTRL_PS_POS]),
        .tsel_wr_i  (wr_data_i[TSEL_W-1:0]),
        .svc_done_i (svc_done),
        .en_o       (cfg_en),
        .presc_o    (cfg_presc),
        .tsel_o     (cfg_tsel)
    );

    wdog_cnt #(
        .BASE_LOG2  (BASE_LOG2),
        .STEP_LOG2  (STEP_LOG2),
        .PRESC_LOG2 (PRESC_LOG2),
        .CNT_W      (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg_en),
        .presc_i  (cfg_presc),
        .tsel_i   (cfg_tsel),
        .reload_i (svc_done),
        .req_o    (rst_req_o)
    );

endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic       wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic       rst_req_o,
    input logic       svc_done,
    input logic       cfg_en,
    input logic       cfg_presc,
    input logic [1:0] cfg_tsel
);

    logic last_arm_q;
    logic ctrl_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_arm_q  <= 1'b0;
            ctrl_seen_q <= 1'b0;
        end else begin
            if (wr_en_i && !wr_sel_i) last_arm_q <= (wr_data_i == 8'h55);
            if (wr_en_i &&  wr_sel_i) ctrl_seen_q <= 1'b1;
        end
    end

    a_r1_done_on_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |-> (wr_en_i && !wr_sel_i && wr_data_i == 8'hAA));

    a_r1_no_req_after_service: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |=> !rst_req_o);

    a_r3_done_needs_prior_key: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |-> last_arm_q);

    a_r5_sel_moves_on_service: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(svc_done) |-> $stable(cfg_tsel));

    a_r7_en_presc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_seen_q) |-> ($stable(cfg_en) && $stable(cfg_presc)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_en) |-> !rst_req_o);

endmodule

bind svc_watchdog svc_watchdog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rst_req_o (rst_req_o),
    .svc_done  (svc_done),
    .cfg_en    (cfg_en),
    .cfg_presc (cfg_presc),
    .cfg_tsel  (cfg_tsel)
);

// File: tb/tb_svc_watchdog.sv
module tb_svc_watchdog;

    localparam int BASE  = 3;
    localparam int STEP  = 1;
    localparam int PRESC = 2;
    localparam int NOREQ = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    svc_watchdog #(
        .BASE_LOG2  (BASE),
        .STEP_LOG2  (STEP),
        .PRESC_LOG2 (PRESC)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rst_req_o (rst_req)
    );

    function automatic int period(input int sel, input int ps);
        return (1 << (BASE + STEP * sel)) * (ps != 0 ? (1 << PRESC) : 1);
    endfunction

    function automatic logic [7:0] ctrl_byte(input int en, input int ps, input int sel);
        return {en[0], 4'b0000, ps[0], sel[1:0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n  = 1'b0;
        strap  = s;
        wr_en  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_req && n < NOREQ);
    endtask

    task automatic count_pulses(input int cycles, output int p);
        p = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rst_req) p++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int p;

        // R6: output quiet while reset is held
        @(negedge clk);
        check("R6 reset state of rst_req_o", int'(rst_req), 0);

        // sweep over strap, prescale and period select
        for (int s = 0; s < 2; s++) begin
            for (int ps = 0; ps < 2; ps++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    do_reset(s[0]);
                    measure(n);
                    check("R6 strap-derived first period", n, period(0, s == 0 ? 1 : 0));
                    @(negedge clk);
                    check("R8 request lasts one clock", int'(rst_req), 0);
                    wr(1'b1, ctrl_byte(1, ps, sel));
                    wr(1'b0, 8'h55);
                    wr(1'b1, ctrl_byte(1, ps, sel));
                    @(negedge clk);
                    wr(1'b0, 8'hAA);
                    measure(n);
                    check("R1 R2 R4 period after service", n, period(sel, ps));
                    measure(n);
                    check("R8 repeat period unserviced", n, period(sel, ps));
                    wr(1'b1, ctrl_byte(0, 1 - ps, sel));
                    wr(1'b0, 8'h55);
                    wr(1'b0, 8'hAA);
                    measure(n);
                    check("R7 enable and prescale locked", n, period(sel, ps));
                end
            end
        end

        // R5: deferred period select
        do_reset(1'b1);
        wr(1'b1, ctrl_byte(1, 0, 3));
        measure(n);
        measure(n);
        check("R5 old period still in force", n, period(0, 0));
        wr(1'b0, 8'h55);
        wr(1'b0, 8'hAA);
        measure(n);
        check("R5 new period after service", n, period(3, 0));

        // R3: lone second key ignored
        wr(1'b0, 8'h55);
        wr(1'b0, 8'hAA);
        wr(1'b0, 8'hAA);
        measure(n);
        check("R3 unarmed second key ignored", n, period(3, 0) - 1);

        // R3: other value cancels a pending first key
        wr(1'b0, 8'h55);
        wr(1'b0, 8'h12);
        wr(1'b0, 8'hAA);
        measure(n);
        check("R3 other value disarms", n, period(3, 0) - 3);

        // R3: keys in reverse order cause expiry
        wr(1'b0, 8'hAA);
        wr(1'b0, 8'h55);
        measure(n);
        check("R3 reversed keys time out", n, period(3, 0) - 2);

        // R1: the pending first key then completes with the second key
        wr(1'b0, 8'hAA);
        measure(n);
        check("R1 armed key completes service", n, period(3, 0));

        // R2: long gap of idle cycles and control writes
        wr(1'b0, 8'h55);
        repeat (20) @(negedge clk);
        wr(1'b1, ctrl_byte(1, 0, 3));
        repeat (10) @(negedge clk);
        wr(1'b1, ctrl_byte(1, 0, 3));
        wr(1'b0, 8'hAA);
        measure(n);
        check("R2 gap between keys tolerated", n, period(3, 0));

        // R9: disabled watchdog stays quiet
        do_reset(1'b1);
        wr(1'b1, ctrl_byte(0, 0, 0));
        count_pulses(300, p);
        check("R9 no request while disabled", p, 0);
        wr(1'b0, 8'h55);
        wr(1'b0, 8'hAA);
        wr(1'b1, ctrl_byte(1, 0, 0));
        count_pulses(300, p);
        check("R9 R7 stays disabled after later writes", p, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule